// File: doc/BRIEF.md
# Pipelined Fixed-Point Quadratic Evaluator

This block evaluates a second-order polynomial `c0 + c1*x + c2*x^2` entirely in integer arithmetic. The offset `x` is an unsigned fraction and the three coefficients are signed fixed-point values. The coefficients are supplied at the ports by whatever table or controller sits upstream. The block takes no part in choosing them, and it does not interpret the result as a floating-point number.

The work is split across three register stages. The first stage forms the full square of `x` and keeps only a narrow, scaled slice of it. The second stage forms the linear product `c1*x` and the quadratic product `c2*sq` side by side. The third stage shifts both products down to the binary scale of `c0` and adds the three terms.

A new evaluation can enter on every clock. A valid flag and a caller-defined tag travel alongside the data, so each result leaves the block exactly three cycles after its operands entered.

Top module: `quad_eval_pipe`

## Requirements
- R1: While `rst` is high on a clock edge, `out_valid` and `out_result` are 0 after that edge.
- R2: `out_valid` equals the `in_valid` value presented three clock edges earlier. Gaps in the input stream appear as gaps at the output in the same positions.
- R3: When `out_valid` is high, `out_tag` equals the `in_tag` presented together with the operands that produced that result.
- R4: The squared term is `sq = floor(x*x / 2^19)`, kept as a 15-bit unsigned value. For the largest `x` (131071) this gives 32767, and for `x = 0` it gives 0.
- R5: The linear product is the two's-complement value `c1 * x`, with `c1` signed and `x` unsigned. It is held in 35 bits without loss.
- R6: The quadratic product is the two's-complement value `c2 * sq`, with `c2` signed (13 bits, range -4096..4095). It is held in 29 bits without loss.
- R7: Before the add, the linear product is shifted right by 14 bits and the quadratic product by 16 bits. Both shifts round toward negative infinity, so for example `-1` shifted right gives `-1`.
- R8: `out_result = c0 + (c1*x >> 14) + (c2*sq >> 16)`, reduced modulo 2^27 and read as a 27-bit two's-complement value. When `c1 = c2 = 0` the result equals `c0`.
- R9: Operands offered on consecutive cycles each yield their own correct result, on consecutive cycles, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on this cycle are to be evaluated |
| in_tag | input | 4 | Caller sideband, returned with the result |
| in_x | input | 17 | Unsigned offset |
| in_c0 | input | 27 | Signed constant term, at the result's scale |
| in_c1 | input | 17 | Signed linear coefficient |
| in_c2 | input | 13 | Signed quadratic coefficient |
| out_valid | output | 1 | Result qualifier |
| out_tag | output | 4 | Tag of the operands behind the result |
| out_result | output | 27 | Signed fixed-point result |

## Verification
The bound checker watches several properties on every cycle:
- the reset clearing of the output stage;
- the three-cycle delay of the valid flag, including bubbles;
- the delay of the tag;
- a zero square for a zero offset;
- pass-through of `c0` when both higher-order coefficients are zero.

The arithmetic itself is shown only by the bench's scenarios. These cover the truncation of the square at the top of the `x` range and floor rounding of negative products. They also cover the extreme coefficient values, wrap-around of the 27-bit sum, and back-to-back streams compared against an independent model.

// File: rtl/quad_pkg.sv
package quad_pkg;
  localparam int unsigned DEF_XW     = 17;
  localparam int unsigned DEF_C0W    = 27;
  localparam int unsigned DEF_C1W    = 17;
  localparam int unsigned DEF_C2W    = 13;
  localparam int unsigned DEF_SQW    = 15;
  localparam int unsigned DEF_SQ_SHR = 19;
  localparam int unsigned DEF_P1_SHR = 14;
  localparam int unsigned DEF_P2_SHR = 16;
  localparam int unsigned DEF_TAGW   = 4;
  localparam int unsigned STAGES     = 3;
endpackage

// File: rtl/quad_sq_stage.sv
module quad_sq_stage #(
  parameter int unsigned XW     = quad_pkg::DEF_XW,
  parameter int unsigned C0W    = quad_pkg::DEF_C0W,
  parameter int unsigned C1W    = quad_pkg::DEF_C1W,
  parameter int unsigned C2W    = quad_pkg::DEF_C2W,
  parameter int unsigned SQW    = quad_pkg::DEF_SQW,
  parameter int unsigned SQ_SHR = quad_pkg::DEF_SQ_SHR,
  parameter int unsigned TAGW   = quad_pkg::DEF_TAGW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  valid_i,
  input  logic [TAGW-1:0]       tag_i,
  input  logic [XW-1:0]         x_i,
  input  logic signed [C0W-1:0] c0_i,
  input  logic signed [C1W-1:0] c1_i,
  input  logic signed [C2W-1:0] c2_i,
  output logic                  valid_o,
  output logic [TAGW-1:0]       tag_o,
  output logic [XW-1:0]         x_o,
  output logic [SQW-1:0]        sq_o,
  output logic signed [C0W-1:0] c0_o,
  output logic signed [C1W-1:0] c1_o,
  output logic signed [C2W-1:0] c2_o
);
  localparam int unsigned FULLW = 2 * XW;

  // Full-width unsigned square, scaled down and cut to the narrow operand
  function automatic logic [SQW-1:0] f_sq_trunc(input logic [XW-1:0] xv);
    logic [FULLW-1:0] xe;
    logic [FULLW-1:0] full;
    logic [FULLW-1:0] scaled;
    xe     = {{(FULLW-XW){1'b0}}, xv};
    full   = xe * xe;
    scaled = full >> SQ_SHR;
    return scaled[SQW-1:0];
  endfunction

  logic [SQW-1:0] sq_next;
  assign sq_next = f_sq_trunc(x_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
      x_o     <= '0;
      sq_o    <= '0;
      c0_o    <= '0;
      c1_o    <= '0;
      c2_o    <= '0;
    end else begin
      valid_o <= valid_i;
      tag_o   <= tag_i;
      x_o     <= x_i;
      sq_o    <= sq_next;
      c0_o    <= c0_i;
      c1_o    <= c1_i;
      c2_o    <= c2_i;
    end
  end
endmodule

// File: rtl/quad_mul_stage.sv
module quad_mul_stage #(
  parameter int unsigned XW   = quad_pkg::DEF_XW,
  parameter int unsigned C0W  = quad_pkg::DEF_C0W,
  parameter int unsigned C1W  = quad_pkg::DEF_C1W,
  parameter int unsigned C2W  = quad_pkg::DEF_C2W,
  parameter int unsigned SQW  = quad_pkg::DEF_SQW,
  parameter int unsigned TAGW = quad_pkg::DEF_TAGW,
  localparam int unsigned P1W = C1W + XW + 1,
  localparam int unsigned P2W = C2W + SQW + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  valid_i,
  input  logic [TAGW-1:0]       tag_i,
  input  logic [XW-1:0]         x_i,
  input  logic [SQW-1:0]        sq_i,
  input  logic signed [C0W-1:0] c0_i,
  input  logic signed [C1W-1:0] c1_i,
  input  logic signed [C2W-1:0] c2_i,
  output logic                  valid_o,
  output logic [TAGW-1:0]       tag_o,
  output logic signed [C0W-1:0] c0_o,
  output logic signed [P1W-1:0] p1_o,
  output logic signed [P2W-1:0] p2_o
);
  // Signed coefficient times unsigned offset, exact in P1W bits
  function automatic logic signed [P1W-1:0] f_lin(input logic signed [C1W-1:0] c,
                                                  input logic [XW-1:0] xv);
    logic signed [P1W-1:0] ce;
    logic signed [P1W-1:0] xe;
    ce = {{(P1W-C1W){c[C1W-1]}}, c};
    xe = {{(P1W-XW){1'b0}}, xv};
    return ce * xe;
  endfunction

  // Signed coefficient times unsigned square slice, exact in P2W bits
  function automatic logic signed [P2W-1:0] f_quad(input logic signed [C2W-1:0] c,
                                                   input logic [SQW-1:0] sv);
    logic signed [P2W-1:0] ce;
    logic signed [P2W-1:0] se;
    ce = {{(P2W-C2W){c[C2W-1]}}, c};
    se = {{(P2W-SQW){1'b0}}, sv};
    return ce * se;
  endfunction

  logic signed [P1W-1:0] p1_next;
  logic signed [P2W-1:0] p2_next;
  assign p1_next = f_lin(c1_i, x_i);
  assign p2_next = f_quad(c2_i, sq_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
      c0_o    <= '0;
      p1_o    <= '0;
      p2_o    <= '0;
    end else begin
      valid_o <= valid_i;
      tag_o   <= tag_i;
      c0_o    <= c0_i;
      p1_o    <= p1_next;
      p2_o    <= p2_next;
    end
  end
endmodule

// File: rtl/quad_sum_stage.sv
module quad_sum_stage #(
  parameter int unsigned C0W    = quad_pkg::DEF_C0W,
  parameter int unsigned P1W    = 35,
  parameter int unsigned P2W    = 29,
  parameter int unsigned P1_SHR = quad_pkg::DEF_P1_SHR,
  parameter int unsigned P2_SHR = quad_pkg::DEF_P2_SHR,
  parameter int unsigned TAGW   = quad_pkg::DEF_TAGW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  valid_i,
  input  logic [TAGW-1:0]       tag_i,
  input  logic signed [C0W-1:0] c0_i,
  input  logic signed [P1W-1:0] p1_i,
  input  logic signed [P2W-1:0] p2_i,
  output logic                  valid_o,
  output logic [TAGW-1:0]       tag_o,
  output logic signed [C0W-1:0] result_o
);
  localparam int unsigned AW = C0W + P1W + P2W;

  // Floor-shift both products to the constant's scale, add, wrap to C0W bits
  function automatic logic signed [C0W-1:0] f_align_sum(input logic signed [C0W-1:0] c0,
                                                        input logic signed [P1W-1:0] p1,
                                                        input logic signed [P2W-1:0] p2);
    logic signed [AW-1:0] a0;
    logic signed [AW-1:0] a1;
    logic signed [AW-1:0] a2;
    logic signed [AW-1:0] acc;
    a0  = {{(AW-C0W){c0[C0W-1]}}, c0};
    a1  = {{(AW-P1W){p1[P1W-1]}}, p1};
    a2  = {{(AW-P2W){p2[P2W-1]}}, p2};
    acc = a0 + (a1 >>> P1_SHR) + (a2 >>> P2_SHR);
    return acc[C0W-1:0];
  endfunction

  logic signed [C0W-1:0] sum_next;
  assign sum_next = f_align_sum(c0_i, p1_i, p2_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      tag_o    <= '0;
      result_o <= '0;
    end else begin
      valid_o  <= valid_i;
      tag_o    <= tag_i;
      result_o <= sum_next;
    end
  end
endmodule

// File: rtl/quad_eval_pipe.sv
module quad_eval_pipe #(
  parameter int unsigned XW     = quad_pkg::DEF_XW,
  parameter int unsigned C0W    = quad_pkg::DEF_C0W,
  parameter int unsigned C1W    = quad_pkg::DEF_C1W,
  parameter int unsigned C2W    = quad_pkg::DEF_C2W,
  parameter int unsigned SQW    = quad_pkg::DEF_SQW,
  parameter int unsigned SQ_SHR = quad_pkg::DEF_SQ_SHR,
  parameter int unsigned P1_SHR = quad_pkg::DEF_P1_SHR,
  parameter int unsigned P2_SHR = quad_pkg::DEF_P2_SHR,
  parameter int unsigned TAGW   = quad_pkg::DEF_TAGW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [TAGW-1:0]       in_tag,
  input  logic [XW-1:0]         in_x,
  input  logic signed [C0W-1:0] in_c0,
  input  logic signed [C1W-1:0] in_c1,
  input  logic signed [C2W-1:0] in_c2,
  output logic                  out_valid,
  output logic [TAGW-1:0]       out_tag,
  output logic signed [C0W-1:0] out_result
);
  localparam int unsigned P1W = C1W + XW + 1;
  localparam int unsigned P2W = C2W + SQW + 1;

  // Named inter-stage signals, visible to the bound checker
  logic                  s1_valid;
  logic [TAGW-1:0]       s1_tag;
  logic [XW-1:0]         s1_x;
  logic [SQW-1:0]        s1_sq;
  logic signed [C0W-1:0] s1_c0;
  logic signed [C1W-1:0] s1_c1;
  logic signed [C2W-1:0] s1_c2;

  logic                  s2_valid;
  logic [TAGW-1:0]       s2_tag;
  logic signed [C0W-1:0] s2_c0;
  logic signed [P1W-1:0] s2_p1;
  logic signed [P2W-1:0] s2_p2;

  quad_sq_stage #(
    .XW(XW), .C0W(C0W), .C1W(C1W), .C2W(C2W),
    .SQW(SQW), .SQ_SHR(SQ_SHR), .TAGW(TAGW)
  ) u_sq (
    .clk(clk), .rst(rst),
    .valid_i(in_valid), .tag_i(in_tag), .x_i(in_x),
    .c0_i(in_c0), .c1_i(in_c1), .c2_i(in_c2),
    .valid_o(s1_valid), .tag_o(s1_tag), .x_o(s1_x), .sq_o(s1_sq),
    .c0_o(s1_c0), .c1_o(s1_c1), .c2_o(s1_c2)
  );

  quad_mul_stage #(
    .XW(XW), .C0W(C0W), .C1W(C1W), .C2W(C2W),
    .SQW(SQW), .TAGW(TAGW)
  ) u_mul (
    .clk(clk), .rst(rst),
    .valid_i(s1_valid), .tag_i(s1_tag), .x_i(s1_x), .sq_i(s1_sq),
    .c0_i(s1_c0), .c1_i(s1_c1), .c2_i(s1_c2),
    .valid_o(s2_valid), .tag_o(s2_tag), .c0_o(s2_c0),
    .p1_o(s2_p1), .p2_o(s2_p2)
  );

  quad_sum_stage #(
    .C0W(C0W), .P1W(P1W), .P2W(P2W),
    .P1_SHR(P1_SHR), .P2_SHR(P2_SHR), .TAGW(TAGW)
  ) u_sum (
    .clk(clk), .rst(rst),
    .valid_i(s2_valid), .tag_i(s2_tag), .c0_i(s2_c0),
    .p1_i(s2_p1), .p2_i(s2_p2),
    .valid_o(out_valid), .tag_o(out_tag), .result_o(out_result)
  );
endmodule

// File: rtl/quad_eval_chk.sv
module quad_eval_chk #(
  parameter int unsigned XW   = 17,
  parameter int unsigned C0W  = 27,
  parameter int unsigned C1W  = 17,
  parameter int unsigned C2W  = 13,
  parameter int unsigned SQW  = 15,
  parameter int unsigned TAGW = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [TAGW-1:0]       in_tag,
  input logic [XW-1:0]         in_x,
  input logic signed [C0W-1:0] in_c0,
  input logic signed [C1W-1:0] in_c1,
  input logic signed [C2W-1:0] in_c2,
  input logic [SQW-1:0]        s1_sq,
  input logic                  out_valid,
  input logic [TAGW-1:0]       out_tag,
  input logic signed [C0W-1:0] out_result
);
  // Clock edges seen since reset was released, saturating at the pipeline depth
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0));

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R3
  tag_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && out_valid) |-> (out_tag == $past(in_tag, 3)));

  // R4
  zero_square_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && $past(in_x) == '0) |-> (s1_sq == '0));

  // R8
  const_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && out_valid && $past(in_c1, 3) == '0 && $past(in_c2, 3) == '0)
      |-> (out_result == $past(in_c0, 3)));
endmodule

bind quad_eval_pipe quad_eval_chk #(
  .XW(XW), .C0W(C0W), .C1W(C1W), .C2W(C2W), .SQW(SQW), .TAGW(TAGW)
) u_quad_eval_chk (
  .clk(clk), .rst(rst),
  .in_valid(in_valid), .in_tag(in_tag), .in_x(in_x),
  .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
  .s1_sq(s1_sq),
  .out_valid(out_valid), .out_tag(out_tag), .out_result(out_result)
);

// File: tb/test_quad_eval_pipe.sv
`timescale 1ns/1ps
module test_quad_eval_pipe;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic [3:0]         in_tag = '0;
  logic [16:0]        in_x = '0;
  logic signed [26:0] in_c0 = '0;
  logic signed [16:0] in_c1 = '0;
  logic signed [12:0] in_c2 = '0;
  logic               out_valid;
  logic [3:0]         out_tag;
  logic signed [26:0] out_result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  quad_eval_pipe i_quad_eval_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag),
    .in_x(in_x), .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
    .out_valid(out_valid), .out_tag(out_tag), .out_result(out_result)
  );

  typedef struct packed {
    logic [16:0]        x;
    logic signed [26:0] c0;
    logic signed [16:0] c1;
    logic signed [12:0] c2;
    logic signed [26:0] res;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{17'd0,      27'sd1000,      17'sd5,      13'sd7,     27'sd1000},
    '{17'd16384,  27'sd0,         17'sd3,      13'sd0,     27'sd3},
    '{17'd131071, 27'sd0,         17'sd0,      13'sd4095,  27'sd2047},
    '{17'd1,      27'sd10,        -17'sd1,     13'sd0,     27'sd9},
    '{17'd131071, 27'sd0,         17'sd0,      -13'sd4096, -27'sd2048},
    '{17'd16384,  27'sd67108863,  17'sd1,      13'sd0,     -27'sd67108864},
    '{17'd131071, 27'sd0,         -17'sd65536, 13'sd0,     -27'sd524284},
    '{17'd65536,  27'sd100,       17'sd2,      13'sd8,     27'sd109}
  };
  localparam string VREQ [NV] = '{"R4", "R5", "R6", "R7", "R6", "R8", "R5", "R8"};

  // Expected-output delay line, one slot per pipeline stage
  bit              ev [3];
  logic [3:0]      et [3];
  longint          er [3];
  string           eq [3];

  function automatic longint floor_div(input longint n, input longint d);
    longint q;
    q = n / d;
    if ((n % d != 0) && (n < 0)) q = q - 1;
    return q;
  endfunction

  // Independent arithmetic model of the requirements
  function automatic longint model(input longint x, input longint c0,
                                   input longint c1, input longint c2);
    longint sq;
    longint t;
    longint m;
    sq = (x * x) / 524288;
    t  = c0 + floor_div(c1 * x, 16384) + floor_div(c2 * sq, 65536);
    m  = t % 134217728;
    if (m < 0) m = m + 134217728;
    if (m >= 67108864) m = m - 134217728;
    return m;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: compare outputs against the slot leaving the pipe, then drive
  task automatic step(input bit v, input logic [3:0] tg, input logic [16:0] x,
                      input logic signed [26:0] c0, input logic signed [16:0] c1,
                      input logic signed [12:0] c2, input longint res, input string req);
    @(negedge clk);
    check("R2", longint'(out_valid), longint'(ev[2]));
    if (ev[2] && out_valid) begin
      check("R3", longint'(out_tag), longint'(et[2]));
      check(eq[2], longint'(out_result), er[2]);
    end
    for (int k = 2; k > 0; k--) begin
      ev[k] = ev[k-1]; et[k] = et[k-1]; er[k] = er[k-1]; eq[k] = eq[k-1];
    end
    ev[0] = v; et[0] = tg; er[0] = res; eq[0] = req;
    in_valid = v; in_tag = tg; in_x = x; in_c0 = c0; in_c1 = c1; in_c2 = c2;
  endtask

  task automatic idle();
    step(1'b0, 4'd0, 17'd0, 27'sd0, 17'sd0, 13'sd0, 0, "R2");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    for (int k = 0; k < 3; k++) begin ev[k] = 1'b0; et[k] = '0; er[k] = 0; eq[k] = "R2"; end
    repeat (3) @(negedge clk);
    check("R1", longint'(out_valid), 0);
    check("R1", longint'(out_result), 0);
    rst = 1'b0;

    // Table, back to back (R9)
    for (int i = 0; i < NV; i++)
      step(1'b1, 4'(i), VECS[i].x, VECS[i].c0, VECS[i].c1, VECS[i].c2,
           longint'(VECS[i].res), VREQ[i]);
    repeat (3) idle();

    // Pseudo-random stream with bubbles, against the model (R8, R9, R2)
    lf = 32'h1234_5678;
    for (int i = 0; i < 60; i++) begin
      logic [16:0] x;
      logic signed [26:0] c0;
      logic signed [16:0] c1;
      logic signed [12:0] c2;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      x = lf[16:0];
      c1 = lf[31:15];
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      c0 = lf[26:0];
      c2 = lf[31:19];
      if (i % 7 == 3) idle();
      step(1'b1, 4'(i), x, c0, c1, c2,
           model(longint'(x), longint'(c0), longint'(c1), longint'(c2)), "R8");
    end
    repeat (3) idle();

    // Reset in the middle of a stream clears the output (R1)
    step(1'b1, 4'd5, 17'd100, 27'sd77, 17'sd1, 13'sd1, 77, "R8");
    step(1'b1, 4'd6, 17'd100, 27'sd77, 17'sd1, 13'sd1, 77, "R8");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", longint'(out_valid), 0);
    check("R1", longint'(out_result), 0);
    in_valid = 1'b0;
    @(negedge clk);
    check("R1", longint'(out_valid), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule